// File: doc/BRIEF.md
# Single-Chain-Active Scan Wrapper

This block holds a bank of scan flip-flops split into several independent scan chains and lets a tester work on exactly one chain at a time. A select code from the tester picks the chain. Only that chain updates on a clock edge, whether the wrapper is shifting or capturing. Every other chain keeps its contents. Toggling activity per edge is therefore limited to one chain's worth of cells, for both the shift cycles and the capture cycle.

The serial input goes to the head of every chain, but only the selected chain takes it in. The serial output comes from the tail cell of the selected chain through a multiplexer. The tester can load one chain, switch the code, and load or capture another chain while the first keeps its pattern. This allows a chain whose bits are shared by consecutive vectors to be left untouched between those vectors.

Each chain is one contiguous slice of the flop vector. The slices are sized by floor division, so every chain gets at least one cell when there are no more chains than flops. Data moves only on the tester's clock and scan-enable. There is no handshake on these pins.

Top module: `scan_chain_gate`

## Requirements
- R1: While `rst_n` is low, every bit of `flop_q` reads 0, whatever the select code is. `scan_out` then reads 0 for every valid code.
- R2: Chain k (0-based) covers `flop_q` bits from floor(k*FLOPS/CHAINS) up to, but not including, floor((k+1)*FLOPS/CHAINS). Its lowest bit is the head cell and its highest bit is the tail cell. A select code c below CHAINS makes chain CHAINS-1-c the active chain. With the defaults (11 flops, 3 chains), code 0 selects bits 10:7, code 1 selects bits 6:3 and code 2 selects bits 2:0.
- R3: With `scan_en` high, each clock edge loads `scan_in` into the head cell of the active chain and moves every other cell of that chain up by one position.
- R4: With `scan_en` low, each clock edge loads every cell of the active chain from the `func_d` bit with the same index.
- R5: The cells of every inactive chain keep their values across shift edges and across capture edges.
- R6: `scan_out` follows the tail cell of the active chain without a register stage. A pattern shifted into a chain therefore leaves it first-in, first-out.
- R7: A select code of CHAINS or more leaves every flop unchanged on shift and capture edges, and forces `scan_out` to 0.
- R8: A chain loaded under one code keeps its pattern while other chains are loaded and captured under different codes. This holds even when the code and `scan_en` change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock shared by all chains |
| rst_n | input | 1 | Asynchronous active-low clear of all cells |
| scan_en | input | 1 | 1 = shift mode, 0 = capture mode |
| scan_in | input | 1 | Serial data offered to the head of every chain |
| chain_sel | input | SEL_W | Tester code selecting the single active chain |
| func_d | input | FLOPS | Functional next-state value for each cell |
| scan_out | output | 1 | Tail cell of the active chain, or 0 for an invalid code |
| flop_q | output | FLOPS | Parallel contents of all cells |

## Verification
On a single edge, the active chain can drop its tail bit on `scan_out` and take in a new head bit from `scan_in`. In the same cycle, a change of select code can coincide with a switch between shift and capture. The bench sets code, mode and data together at the falling edge before every rising edge. It checks `scan_out` against a reference array before the edge and the whole `flop_q` vector after it. The bit stream shifted out of a loaded chain is also compared as a vector against the loaded pattern, so a missing or doubled shift position shows up even where the cell-by-cell check would not catch it.

// File: rtl/scan_gate_pkg.sv
package scan_gate_pkg;

  // First flop index owned by chain k when flops are split evenly by floor.
  function automatic int chain_base(input int k, input int flops, input int chains);
    return (k * flops) / chains;
  endfunction

  // Number of cells in chain k.
  function automatic int chain_len(input int k, input int flops, input int chains);
    return chain_base(k + 1, flops, chains) - chain_base(k, flops, chains);
  endfunction

  // Width of the tester select code.
  function automatic int sel_width(input int chains);
    return (chains > 1) ? $clog2(chains) : 1;
  endfunction

endpackage

// File: rtl/scan_sel_decode.sv
module scan_sel_decode #(
  parameter int CHAINS = 3,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel_code,
  output logic [CHAINS-1:0] chain_en
);

  // Code c enables chain CHAINS-1-c; codes at or above CHAINS enable nothing.
  for (genvar k = 0; k < CHAINS; k++) begin : g_dec
    assign chain_en[k] = (sel_code == SEL_W'(CHAINS - 1 - k));
  end

endmodule

// File: rtl/scan_cell_chain.sv
module scan_cell_chain #(
  parameter int LEN = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           chain_en,
  input  logic           shift_mode,
  input  logic           serial_in,
  input  logic [LEN-1:0] capture_d,
  output logic [LEN-1:0] cells,
  output logic           tail
);

  logic [LEN-1:0] upstream;
  logic [LEN-1:0] next_val;

  // Head cell takes the serial input, every other cell its lower neighbour.
  if (LEN == 1) begin : g_single
    assign upstream = serial_in;
  end else begin : g_multi
    assign upstream = {cells[LEN-2:0], serial_in};
  end

  assign next_val = shift_mode ? upstream : capture_d;

  // Clock enable stands in for a gated chain clock: a disabled chain never moves.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells <= '0;
    end else if (chain_en) begin
      cells <= next_val;
    end
  end

  assign tail = cells[LEN-1];

endmodule

// File: rtl/scan_out_mux.sv
module scan_out_mux #(
  parameter int CHAINS = 3
) (
  input  logic [CHAINS-1:0] tails,
  input  logic [CHAINS-1:0] chain_en,
  output logic              serial_out
);

  // Select is one-hot or empty, so an AND-OR tree serves as the multiplexer.
  assign serial_out = |(tails & chain_en);

endmodule

// File: rtl/scan_chain_gate.sv
module scan_chain_gate
  import scan_gate_pkg::*;
#(
  parameter  int FLOPS  = 11,
  parameter  int CHAINS = 3,
  localparam int SEL_W  = sel_width(CHAINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             scan_in,
  input  logic [SEL_W-1:0] chain_sel,
  input  logic [FLOPS-1:0] func_d,
  output logic             scan_out,
  output logic [FLOPS-1:0] flop_q
);

  logic [CHAINS-1:0] chain_en;
  logic [CHAINS-1:0] tails;

  scan_sel_decode #(
    .CHAINS (CHAINS),
    .SEL_W  (SEL_W)
  ) u_decode (
    .sel_code (chain_sel),
    .chain_en (chain_en)
  );

  for (genvar k = 0; k < CHAINS; k++) begin : g_chain
    localparam int BASE = chain_base(k, FLOPS, CHAINS);
    localparam int LEN  = chain_len(k, FLOPS, CHAINS);

    scan_cell_chain #(
      .LEN (LEN)
    ) u_chain (
      .clk        (clk),
      .rst_n      (rst_n),
      .chain_en   (chain_en[k]),
      .shift_mode (scan_en),
      .serial_in  (scan_in),
      .capture_d  (func_d[BASE +: LEN]),
      .cells      (flop_q[BASE +: LEN]),
      .tail       (tails[k])
    );
  end

  scan_out_mux #(
    .CHAINS (CHAINS)
  ) u_mux (
    .tails      (tails),
    .chain_en   (chain_en),
    .serial_out (scan_out)
  );

endmodule

// File: rtl/scan_chain_gate_chk.sv
module scan_chain_gate_chk #(
  parameter int FLOPS  = 11,
  parameter int CHAINS = 3,
  parameter int SEL_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scan_en,
  input logic             scan_in,
  input logic [SEL_W-1:0] chain_sel,
  input logic [FLOPS-1:0] func_d,
  input logic             scan_out,
  input logic [FLOPS-1:0] flop_q
);

  logic [CHAINS-1:0] act;
  logic [FLOPS-1:0]  idle_mask;

  always_comb begin
    act = '0;
    for (int k = 0; k < CHAINS; k++) begin
      if (int'(chain_sel) == CHAINS - 1 - k) act[k] = 1'b1;
    end
    idle_mask = '1;
    for (int k = 0; k < CHAINS; k++) begin
      for (int i = 0; i < FLOPS; i++) begin
        if (act[k] && i >= (k * FLOPS) / CHAINS && i < ((k + 1) * FLOPS) / CHAINS)
          idle_mask[i] = 1'b0;
      end
    end
  end

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flop_q ^ $past(flop_q)) & $past(idle_mask)) == '0);

  assert_bad_code_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chain_sel) >= CHAINS) |=> $stable(flop_q));

  assert_bad_code_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(chain_sel) >= CHAINS) |-> !scan_out);

  for (genvar k = 0; k < CHAINS; k++) begin : g_prop
    localparam int B = (k * FLOPS) / CHAINS;
    localparam int L = ((k + 1) * FLOPS) / CHAINS - B;

    assert_head_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (act[k] && scan_en) |=> flop_q[B] == $past(scan_in));

    assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (act[k] && !scan_en) |=> flop_q[B +: L] == $past(func_d[B +: L]));

    assert_tail_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
      act[k] |-> scan_out == flop_q[B + L - 1]);
  end

endmodule

bind scan_chain_gate scan_chain_gate_chk #(
  .FLOPS  (FLOPS),
  .CHAINS (CHAINS),
  .SEL_W  (SEL_W)
) u_chk (.*);

// File: tb/scan_chain_gate_test.sv
module scan_chain_gate_test;
  localparam int F  = 11;
  localparam int N  = 3;
  localparam int SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0;
  logic          scan_in = 1'b0;
  logic [SW-1:0] chain_sel = '0;
  logic [F-1:0]  func_d = '0;
  wire           scan_out;
  wire  [F-1:0]  flop_q;

  logic [F-1:0]  model = '0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scan_chain_gate #(.FLOPS(F), .CHAINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_in(scan_in),
    .chain_sel(chain_sel), .func_d(func_d), .scan_out(scan_out), .flop_q(flop_q)
  );

  function automatic int base_of(input int k);
    return (k * F) / N;
  endfunction

  function automatic logic exp_so(input logic [SW-1:0] s);
    if (int'(s) >= N) return 1'b0;
    return model[base_of(N - int'(s)) - 1];
  endfunction

  task automatic chk(input string tag, input logic [F-1:0] got, input logic [F-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Drives one edge at a falling edge; checks scan_out before and flops after.
  task automatic step(input string tag, input logic [SW-1:0] s, input logic se,
                      input logic si, input logic [F-1:0] d);
    logic [F-1:0] nxt;
    nxt = model;
    chain_sel = s; scan_en = se; scan_in = si; func_d = d;
    #1 chk({tag, " R6 scan_out"}, F'(scan_out), F'(exp_so(s)));
    if (int'(s) < N) begin
      int k;
      k = N - 1 - int'(s);
      for (int i = base_of(k); i < base_of(k + 1); i++)
        nxt[i] = se ? ((i == base_of(k)) ? si : model[i - 1]) : d[i];
    end
    @(posedge clk);
    model = nxt;
    @(negedge clk);
    chk({tag, " flops"}, flop_q, model);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chain_sel = 2'd1; scan_en = 1'b1; scan_in = 1'b1; func_d = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset flops", flop_q, '0);
    chk("R1 reset scan_out", F'(scan_out), '0);
    rst_n = 1'b1;
    model = '0;
  endtask

  task automatic t_shift_fill();
    step("R3 fill", 2'd2, 1'b1, 1'b1, '0);
    step("R3 fill", 2'd2, 1'b1, 1'b1, '0);
    step("R3 fill", 2'd2, 1'b1, 1'b0, '0);
    chk("R2 R3 chain0 bits 2:0", F'(flop_q[2:0]), F'(3'b110));
    chk("R5 other chains after fill", F'(flop_q[10:3]), '0);
  endtask

  task automatic t_stream_out();
    logic [3:0] seen;
    logic [3:0] pat;
    pat = 4'b1001;
    for (int i = 3; i >= 0; i--) step("R3 load chain1", 2'd1, 1'b1, pat[i], '0);
    chk("R2 chain1 bits 6:3", F'(flop_q[6:3]), F'(4'b1001));
    for (int i = 3; i >= 0; i--) begin
      chain_sel = 2'd1; scan_en = 1'b1; scan_in = 1'b0;
      #1 seen[i] = scan_out;
      step("R6 drain chain1", 2'd1, 1'b1, 1'b0, '0);
    end
    chk("R6 serial order", F'(seen), F'(pat));
  endtask

  task automatic t_capture();
    logic [F-1:0] pre;
    pre = flop_q;
    step("R4 capture chain2", 2'd0, 1'b0, 1'b0, 11'h5A5);
    chk("R4 chain2 bits 10:7", F'(flop_q[10:7]), F'(4'b1011));
    chk("R5 capture leaves 6:0", F'(flop_q[6:0]), F'(pre[6:0]));
  endtask

  task automatic t_invalid();
    logic [F-1:0] pre;
    pre = flop_q;
    step("R7 bad code shift", 2'd3, 1'b1, 1'b1, '1);
    step("R7 bad code capture", 2'd3, 1'b0, 1'b1, ~pre);
    chk("R7 all flops frozen", flop_q, pre);
    chk("R7 scan_out zero", F'(scan_out), '0);
  endtask

  task automatic t_reuse();
    logic [F-1:0] pre;
    step("R8 reload chain0", 2'd2, 1'b1, 1'b0, '0);
    pre = flop_q;
    step("R8 switch to chain1 capture", 2'd1, 1'b0, 1'b1, 11'h078);
    step("R8 switch to chain2 shift", 2'd0, 1'b1, 1'b1, '0);
    step("R8 chain2 capture", 2'd0, 1'b0, 1'b0, 11'h000);
    chk("R8 chain0 kept", F'(flop_q[2:0]), F'(pre[2:0]));
    chk("R8 chain1 captured", F'(flop_q[6:3]), F'(4'b1111));
    chk("R8 chain2 cleared", F'(flop_q[10:7]), '0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 1'b0;
    #2 chk("R1 async clear mid-run", flop_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    model = '0;
    chain_sel = 2'd0;
    #1 chk("R1 scan_out after clear", F'(scan_out), '0);
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    if (!done) $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_shift_fill();
    t_stream_out();
    t_capture();
    t_invalid();
    t_reuse();
    t_reset_mid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule